// File: doc/BRIEF.md
# DRAM Command Decoder and Bank State Tracker

This block watches the command path of a double-data-rate DRAM device model or controller checker. Each cycle in which `cmd_valid` is high it takes one command (row activate, read, write or precharge) together with the bank-group, bank and address pins. It keeps, for every bank, whether a row is open and which row that is. A read or write to a bank that is ready produces a one-cycle access report that gives the bank, starting column, row, direction, auto-precharge request and effective burst length.

Commands that break the open/closed discipline are not applied. Instead they raise a one-cycle error pulse: a column access to a bank with no usable row, or an activate to a bank whose row is still open. Auto-precharge is tracked per bank. The bank counts out the data beats of its burst at two beats per clock and then closes by itself. The parameter `WIDE_ORG` selects the organisation. When it is 0 the block has 16 banks in 4 groups of 4 and a two-bit group field. When it is 1 the block has 8 banks in 2 groups of 4 and a one-bit group field.

Top module: `dram_cmd_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every bank is closed after that edge and `acc_valid`, `err_no_row` and `err_row_open` are low.
- R2: An activate (`cmd_code` 0) to a closed bank opens it and stores `addr_in[17:0]` as its row. The bank's `bank_open` bit is high after the accepting edge.
- R3: The bank index is `{bg_in, ba_in}`, with the group in the upper bits. `bg_in` is 2 bits wide (16 banks) when `WIDE_ORG` is 0 and 1 bit wide (8 banks) when it is 1.
- R4: A read (`cmd_code` 1) or write (`cmd_code` 2) to an open, idle bank gives, one edge later, a single-cycle `acc_valid`. With it come `acc_write` (1 for write), `acc_bank`, `acc_col` = `addr_in[9:0]` and `acc_row` = the bank's stored row.
- R5: A read or write to a closed bank gives a single-cycle `err_no_row`, no `acc_valid`, and no change to any bank.
- R6: An activate to an open bank gives a single-cycle `err_row_open` and leaves that bank's stored row unchanged.
- R7: `addr_in[10]` high on an accepted read or write sets `acc_ap`. The bank's `bank_open` bit then clears 4 clock edges after the accepting edge for a burst of 8, or 2 edges after it for a burst chop of 4.
- R8: With `otf_en` high, `addr_in[12]` on a read or write selects the length: 1 gives `acc_len` = 8 and 0 gives `acc_len` = 4.
- R9: With `otf_en` low, `cfg_bl8` selects the length (1 gives 8, 0 gives 4) and `addr_in[12]` has no effect.
- R10: A precharge (`cmd_code` 3) with `addr_in[10]` high closes every bank. With it low, only the addressed bank closes and any auto-precharge countdown pending on that bank is cancelled.
- R11: A read or write to a bank whose auto-precharge countdown is still running is treated as an access to a closed bank (R5).
- R12: With `cmd_valid` low, no bank changes state and no report or error is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| bg_in | input | WIDE_ORG ? 1 : 2 | Bank-group select |
| ba_in | input | 2 | Bank within group |
| addr_in | input | 18 | Row address, or column plus control bits |
| otf_en | input | 1 | Burst length chosen per access by `addr_in[12]` |
| cfg_bl8 | input | 1 | Fixed burst length when `otf_en` is low (1 = 8) |
| acc_valid | output | 1 | Access report valid |
| acc_write | output | 1 | Reported access is a write |
| acc_bank | output | BG_W+2 | Reported bank index |
| acc_col | output | 10 | Reported starting column |
| acc_row | output | 18 | Open row of the reported bank |
| acc_ap | output | 1 | Auto-precharge requested |
| acc_len | output | 4 | Effective burst length (8 or 4) |
| err_no_row | output | 1 | Access to a bank without a usable row |
| err_row_open | output | 1 | Activate to a bank that is already open |
| bank_open | output | NBANK | Per-bank open flag |

## Verification
The bench aims at the auto-precharge countdown. It checks that the bank stays open through the last beat and closes on the fourth edge for a burst of 8 and on the second edge for a burst chop of 4. A design off by one would close one cycle early or late, and a design that ignored the chop would hold a BC4 bank open two cycles too long. It also sends an access while the countdown is running, which a design that only looked at the open flag would accept. It then sends a single-bank precharge followed by an activate during a countdown; a stale timer would close the newly opened row behind the user's back. Finally, it repeats an activate on an open bank and sets `addr_in[12]` with `otf_en` low, which catches a design that overwrites the row or lets the address bit override the fixed length.

// File: rtl/cmdtrk_pkg.sv
package cmdtrk_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    localparam int ROW_W  = 18;
    localparam int COL_W  = 10;
    localparam int BA_W   = 2;
    localparam int AP_BIT = 10;
    localparam int BC_BIT = 12;
    localparam int LEN_W  = 4;
    localparam int TMR_W  = 3;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
    } cmd_flags_t;

    // effective burst length in data words
    function automatic logic [LEN_W-1:0] burst_len(input logic bl8);
        return bl8 ? 4'd8 : 4'd4;
    endfunction

    // two data words move per clock, so the burst lasts half its length in cycles
    function automatic logic [TMR_W-1:0] burst_cycles(input logic bl8);
        return bl8 ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/cmdtrk_decode.sv
module cmdtrk_decode
    import cmdtrk_pkg::*;
#(
    parameter int BG_W   = 2,
    parameter int BANK_W = BG_W + 2
) (
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_code,
    input  logic [BG_W-1:0]      bg_in,
    input  logic [BA_W-1:0]      ba_in,
    input  logic [ROW_W-1:0]     addr_in,
    input  logic                 otf_en,
    input  logic                 cfg_bl8,
    output cmd_flags_t           flags,
    output logic [BANK_W-1:0]    bank,
    output logic [COL_W-1:0]     col,
    output logic                 ap,
    output logic                 bl8
);

    always_comb begin
        flags = '0;
        if (cmd_valid) begin
            unique case (cmd_e'(cmd_code))
                CMD_ACT: flags.act = 1'b1;
                CMD_RD:  flags.rd  = 1'b1;
                CMD_WR:  flags.wr  = 1'b1;
                CMD_PRE: flags.pre = 1'b1;
                default: flags     = '0;
            endcase
        end
    end

    assign bank = {bg_in, ba_in};
    assign col  = addr_in[COL_W-1:0];
    assign ap   = addr_in[AP_BIT];
    assign bl8  = otf_en ? addr_in[BC_BIT] : cfg_bl8;

endmodule

// File: rtl/cmdtrk_bank.sv
module cmdtrk_bank
    import cmdtrk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               act_go,
    input  logic               ap_go,
    input  logic               pre_go,
    input  logic [ROW_W-1:0]   row_in,
    input  logic [TMR_W-1:0]   ap_cycles,
    output logic               is_open,
    output logic               busy,
    output logic [ROW_W-1:0]   row_q
);

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row_q   <= '0;
            cnt     <= '0;
        end else if (pre_go) begin
            is_open <= 1'b0;
            cnt     <= '0;
        end else if (act_go) begin
            is_open <= 1'b1;
            row_q   <= row_in;
        end else if (ap_go) begin
            cnt <= ap_cycles;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == TMR_W'(1)) is_open <= 1'b0;
        end
    end

    assign busy = (cnt != '0);

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        is_open |=> $stable(row_q));

    // R7
    close_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(is_open) |-> $past(pre_go || cnt == TMR_W'(1)));

    // R10
    pre_close_chk: assert property (@(posedge clk) disable iff (rst)
        pre_go |=> !is_open);

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
    import cmdtrk_pkg::*;
#(
    parameter int WIDE_ORG = 0,
    parameter int BG_W     = (WIDE_ORG != 0) ? 1 : 2,
    parameter int BANK_W   = BG_W + BA_W,
    parameter int NBANK    = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_code,
    input  logic [BG_W-1:0]      bg_in,
    input  logic [BA_W-1:0]      ba_in,
    input  logic [ROW_W-1:0]     addr_in,
    input  logic                 otf_en,
    input  logic                 cfg_bl8,
    output logic                 acc_valid,
    output logic                 acc_write,
    output logic [BANK_W-1:0]    acc_bank,
    output logic [COL_W-1:0]     acc_col,
    output logic [ROW_W-1:0]     acc_row,
    output logic                 acc_ap,
    output logic [LEN_W-1:0]     acc_len,
    output logic                 err_no_row,
    output logic                 err_row_open,
    output logic [NBANK-1:0]     bank_open
);

    cmd_flags_t          flags;
    logic [BANK_W-1:0]   dec_bank;
    logic [COL_W-1:0]    dec_col;
    logic                dec_ap;
    logic                dec_bl8;

    cmdtrk_decode #(.BG_W(BG_W), .BANK_W(BANK_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .bg_in     (bg_in),
        .ba_in     (ba_in),
        .addr_in   (addr_in),
        .otf_en    (otf_en),
        .cfg_bl8   (cfg_bl8),
        .flags     (flags),
        .bank      (dec_bank),
        .col       (dec_col),
        .ap        (dec_ap),
        .bl8       (dec_bl8)
    );

    logic [NBANK-1:0]  busy_vec;
    logic [ROW_W-1:0]  rows [NBANK];
    logic              col_cmd;
    logic              acc_ok;
    logic              acc_bad;
    logic              act_ok;
    logic              act_bad;
    logic              sel_open;
    logic              sel_busy;

    assign sel_open = bank_open[dec_bank];
    assign sel_busy = busy_vec[dec_bank];
    assign col_cmd  = flags.rd | flags.wr;
    assign acc_ok   = col_cmd & sel_open & ~sel_busy;
    assign acc_bad  = col_cmd & ~acc_ok;
    assign act_ok   = flags.act & ~sel_open;
    assign act_bad  = flags.act & sel_open;

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic hit;
        assign hit = (dec_bank == BANK_W'(i));

        cmdtrk_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .act_go    (act_ok & hit),
            .ap_go     (acc_ok & dec_ap & hit),
            .pre_go    (flags.pre & (dec_ap | hit)),
            .row_in    (addr_in),
            .ap_cycles (burst_cycles(dec_bl8)),
            .is_open   (bank_open[i]),
            .busy      (busy_vec[i]),
            .row_q     (rows[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid    <= 1'b0;
            acc_write    <= 1'b0;
            acc_bank     <= '0;
            acc_col      <= '0;
            acc_row      <= '0;
            acc_ap       <= 1'b0;
            acc_len      <= '0;
            err_no_row   <= 1'b0;
            err_row_open <= 1'b0;
        end else begin
            acc_valid    <= acc_ok;
            err_no_row   <= acc_bad;
            err_row_open <= act_bad;
            if (acc_ok) begin
                acc_write <= flags.wr;
                acc_bank  <= dec_bank;
                acc_col   <= dec_col;
                acc_row   <= rows[dec_bank];
                acc_ap    <= dec_ap;
                acc_len   <= burst_len(dec_bl8);
            end
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (bank_open == '0 && !acc_valid && !err_no_row && !err_row_open));

    // R5
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_valid, err_no_row, err_row_open}));

    // R8
    len_legal_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_len == 4'd8 || acc_len == 4'd4));

    // R4
    valid_open_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> bank_open[acc_bank]);

endmodule

// File: tb/sim_dram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_dram_cmd_tracker;
    import cmdtrk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_code = 2'd0;
    logic [1:0]  bg_in = 2'd0;
    logic [1:0]  ba_in = 2'd0;
    logic [17:0] addr_in = '0;
    logic        otf_en = 1'b1;
    logic        cfg_bl8 = 1'b1;
    logic        acc_valid, acc_write, acc_ap, err_no_row, err_row_open;
    logic [3:0]  acc_bank;
    logic [9:0]  acc_col;
    logic [17:0] acc_row;
    logic [3:0]  acc_len;
    logic [15:0] bank_open;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dram_cmd_tracker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .bg_in(bg_in), .ba_in(ba_in), .addr_in(addr_in), .otf_en(otf_en),
        .cfg_bl8(cfg_bl8), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_col(acc_col), .acc_row(acc_row),
        .acc_ap(acc_ap), .acc_len(acc_len), .err_no_row(err_no_row),
        .err_row_open(err_row_open), .bank_open(bank_open)
    );

    typedef struct packed {
        logic [1:0]  cmd;
        logic [1:0]  bg;
        logic [1:0]  ba;
        logic [17:0] addr;
        logic        otf;
        logic        cfg;
        logic        ev;
        logic        enr;
        logic        ero;
        logic [3:0]  elen;
        logic [3:0]  ebank;
        logic [9:0]  ecol;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd1, 2'd2, 18'h2A5A5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0,  10'h000}, // R2 open bank 6
        '{2'd1, 2'd1, 2'd2, 18'h01155, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 4'd6,  10'h155}, // R4 R8 read BL8
        '{2'd2, 2'd1, 2'd2, 18'h000A3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 4'd6,  10'h0A3}, // R8 write BC4
        '{2'd1, 2'd1, 2'd1, 18'h00000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0,  10'h000}, // R5 closed bank
        '{2'd0, 2'd1, 2'd2, 18'h11111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0,  10'h000}, // R6 reopen
        '{2'd0, 2'd3, 2'd3, 18'h3FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0,  10'h000}, // R3 bank 15
        '{2'd1, 2'd3, 2'd3, 18'h00007, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 4'd15, 10'h007}, // R9 fixed 8
        '{2'd1, 2'd3, 2'd3, 18'h01008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 4'd15, 10'h008}, // R9 bit12 ignored
        '{2'd3, 2'd1, 2'd2, 18'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0,  10'h000}, // R10 single
        '{2'd1, 2'd1, 2'd2, 18'h00001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0,  10'h000}, // R10 now closed
        '{2'd1, 2'd3, 2'd3, 18'h003FF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 4'd15, 10'h3FF}, // R4 top column
        '{2'd3, 2'd0, 2'd0, 18'h00400, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0,  10'h000}, // R10 all
        '{2'd2, 2'd3, 2'd3, 18'h00000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0,  10'h000}  // R10 all closed
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic [1:0] g,
                         input logic [1:0] b, input logic [17:0] a,
                         input logic o, input logic f);
        cmd_valid = v; cmd_code = c; bg_in = g; ba_in = b;
        addr_in = a; otf_en = o; cfg_bl8 = f;
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 bank_open", 32'(bank_open), 32'h0);
        chk("R1 acc_valid", 32'(acc_valid), 32'h0);
        chk("R1 errors", 32'({err_no_row, err_row_open}), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TBL[i].cmd, TBL[i].bg, TBL[i].ba, TBL[i].addr, TBL[i].otf, TBL[i].cfg);
            step();
            chk($sformatf("R4 vec%0d acc_valid", i), 32'(acc_valid), 32'(TBL[i].ev));
            chk($sformatf("R5 vec%0d err_no_row", i), 32'(err_no_row), 32'(TBL[i].enr));
            chk($sformatf("R6 vec%0d err_row_open", i), 32'(err_row_open), 32'(TBL[i].ero));
            if (TBL[i].ev) begin
                chk($sformatf("R8 vec%0d acc_len", i), 32'(acc_len), 32'(TBL[i].elen));
                chk($sformatf("R3 vec%0d acc_bank", i), 32'(acc_bank), 32'(TBL[i].ebank));
                chk($sformatf("R4 vec%0d acc_col", i), 32'(acc_col), 32'(TBL[i].ecol));
                chk($sformatf("R4 vec%0d acc_write", i), 32'(acc_write), 32'(TBL[i].cmd == 2'd2));
                chk($sformatf("R7 vec%0d acc_ap", i), 32'(acc_ap), 32'h0);
            end
            if (i == 0) chk("R2 R3 bank6 open", 32'(bank_open), 32'h0040);
            if (i == 6) chk("R4 acc_row bank15", 32'(acc_row), 32'h3FFFF);
            if (i == 11) chk("R10 all closed", 32'(bank_open), 32'h0);
        end
        idle();

        // R6 stored row kept after repeated activate
        drive(1'b1, 2'd0, 2'd0, 2'd2, 18'h12345, 1'b1, 1'b1); step();
        drive(1'b1, 2'd1, 2'd0, 2'd2, 18'h01000, 1'b1, 1'b1); step();
        chk("R2 acc_row", 32'(acc_row), 32'h12345);
        drive(1'b1, 2'd0, 2'd0, 2'd2, 18'h00FFF, 1'b1, 1'b1); step();
        chk("R6 err_row_open", 32'(err_row_open), 32'h1);
        drive(1'b1, 2'd1, 2'd0, 2'd2, 18'h01000, 1'b1, 1'b1); step();
        chk("R6 row unchanged", 32'(acc_row), 32'h12345);

        // R7 auto-precharge BL8, R11 access during countdown
        drive(1'b1, 2'd0, 2'd0, 2'd0, 18'h00005, 1'b1, 1'b1); step();
        drive(1'b1, 2'd1, 2'd0, 2'd0, 18'h01410, 1'b1, 1'b1); step();   // E0
        chk("R7 acc_ap", 32'(acc_ap), 32'h1);
        chk("R7 acc_len", 32'(acc_len), 32'h8);
        chk("R7 open at E0", 32'(bank_open[0]), 32'h1);
        idle(); step();                                                 // E1
        chk("R7 open at E1", 32'(bank_open[0]), 32'h1);
        drive(1'b1, 2'd1, 2'd0, 2'd0, 18'h00020, 1'b1, 1'b1); step();   // E2
        chk("R11 err_no_row", 32'(err_no_row), 32'h1);
        chk("R11 no acc_valid", 32'(acc_valid), 32'h0);
        idle(); step();                                                 // E3
        chk("R7 open at E3", 32'(bank_open[0]), 32'h1);
        step();                                                         // E4
        chk("R7 closed at E4", 32'(bank_open[0]), 32'h0);

        // R7 auto-precharge BC4
        drive(1'b1, 2'd0, 2'd0, 2'd3, 18'h00007, 1'b1, 1'b1); step();
        drive(1'b1, 2'd1, 2'd0, 2'd3, 18'h00400, 1'b1, 1'b1); step();   // E0
        chk("R7 bc4 len", 32'(acc_len), 32'h4);
        idle(); step();                                                 // E1
        chk("R7 bc4 open at E1", 32'(bank_open[3]), 32'h1);
        step();                                                         // E2
        chk("R7 bc4 closed at E2", 32'(bank_open[3]), 32'h0);

        // R10 single precharge cancels countdown, leaves other banks
        drive(1'b1, 2'd0, 2'd0, 2'd1, 18'h00009, 1'b1, 1'b1); step();
        drive(1'b1, 2'd1, 2'd0, 2'd1, 18'h01400, 1'b1, 1'b1); step();   // E0
        drive(1'b1, 2'd3, 2'd0, 2'd1, 18'h00000, 1'b1, 1'b1); step();   // E1
        chk("R10 bank1 closed", 32'(bank_open[1]), 32'h0);
        chk("R10 bank2 kept", 32'(bank_open[2]), 32'h1);
        drive(1'b1, 2'd0, 2'd0, 2'd1, 18'h0000A, 1'b1, 1'b1); step();   // E2
        chk("R10 reopen no error", 32'({err_no_row, err_row_open}), 32'h0);
        idle(); step(); step(); step();
        chk("R10 no stale close", 32'(bank_open[1]), 32'h1);

        // R12 commands ignored without cmd_valid
        drive(1'b0, 2'd0, 2'd2, 2'd1, 18'h00001, 1'b1, 1'b1); step();
        chk("R12 act ignored", 32'(bank_open[9]), 32'h0);
        drive(1'b0, 2'd1, 2'd0, 2'd2, 18'h00001, 1'b1, 1'b1); step();
        chk("R12 read ignored", 32'({acc_valid, err_no_row, err_row_open}), 32'h0);
        drive(1'b0, 2'd3, 2'd0, 2'd0, 18'h00400, 1'b1, 1'b1); step();
        chk("R12 pre ignored", 32'(bank_open[2]), 32'h1);

        // R3 group 2 bank 1 maps to index 9
        drive(1'b1, 2'd0, 2'd2, 2'd1, 18'h00001, 1'b1, 1'b1); step();
        chk("R3 bank9 open", 32'(bank_open[9]), 32'h1);
        idle(); step();

        finish_run();
    end

endmodule